// File: doc/BRIEF.md
# Execute-stage ALU operand forwarding selector

This block chooses the two operands that feed the ALU in the execute stage of a five-stage in-order pipeline. It looks at three instruction words: the one about to execute and the two older ones still in flight ahead of it. It also receives every candidate operand value: the next-instruction address, the two register-file reads, the sign-extended immediate, the ALU result waiting in the memory stage and the load data waiting in the write-back stage. For each ALU input it produces a one-hot select code and the selected value.

A read-after-write dependency on an older instruction is resolved by taking the newer value from the pipeline rather than the stale register read. The block does not insert stalls. A load that is directly followed by a dependent instruction must still be held one cycle by separate interlock logic. After that cycle this block supplies the loaded word from the write-back stage. Selects and operands are registered, so they appear one clock after the instruction words that produced them.

Instruction fields are numbered from the most significant bit, so field bit 0 is word bit 31. The opcode is bits 0..5. The first source register is bits 6..10. The second register field is bits 11..15, and it holds the destination for immediate-form instructions. A register-form destination is bits 16..20, and the function code is bits 21..31. Default opcodes are: register ALU 1, immediate ALU 8, load 35, store 43, branch 4. Any other opcode, including jump (2) and the all-zero no-op, neither reads nor writes a register.

Top module: `alu_fwd_sel`

## Requirements
- R1: While reset is high on a clock edge, both select outputs become 4'b0001 and both operand outputs become zero, whatever the inputs are.
- R2: Select and operand outputs reflect the inputs sampled at the previous rising clock edge (one register stage).
- R3: The lower select is 4'b0010 (immediate) when the execute-stage opcode is immediate ALU, load, store or branch.
- R4: For a register-form execute instruction with no immediate, the lower select is 4'b0100 (memory-stage ALU result) when bits 11..15 equal the destination of a memory-stage register-ALU (bits 16..20) or immediate-ALU (bits 11..15) instruction.
- R5: Failing R4, the lower select is 4'b1000 (write-back load data) when the write-back instruction is a load whose bits 11..15 equal the execute bits 11..15.
- R6: The upper select is 4'b0010 (next-instruction address) when the execute-stage opcode is branch.
- R7: For a non-branch execute instruction that reads bits 6..10 (register ALU, immediate ALU, load, store), the upper select follows the same order as R4 and R5: memory-stage result (4'b0100), then write-back load data (4'b1000).
- R8: When the memory-stage and write-back producers both match the same source, the memory-stage ALU result is chosen.
- R9: Store, branch, jump and no-op words never cause a forwarding match, a load in the memory stage is never forwarded, and a write-back instruction that is not a load is never forwarded.
- R10: When no rule above applies, including every jump or no-op in the execute stage, the upper select is 4'b0001 (register A) and the lower select is 4'b0001 (register B).
- R11: Each select output has exactly one bit set, and each operand output equals the candidate that its select names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_insn | input | 32 | Instruction word in the execute stage |
| mem_insn | input | 32 | Instruction word one stage older (memory stage) |
| wb_insn | input | 32 | Instruction word two stages older (write-back stage) |
| next_pc | input | DW | Next-instruction address of the execute instruction |
| rf_a | input | DW | First register-file read |
| rf_b | input | DW | Second register-file read |
| imm_ext | input | DW | Sign-extended immediate |
| mem_alu_res | input | DW | ALU result held in the memory stage |
| wb_load_data | input | DW | Load data held in the write-back stage |
| opnd_hi | output | DW | Selected upper ALU operand |
| opnd_lo | output | DW | Selected lower ALU operand |
| sel_hi | output | 4 | One-hot upper select: bit0 A, bit1 next address, bit2 memory result, bit3 load data |
| sel_lo | output | 4 | One-hot lower select: bit0 B, bit1 immediate, bit2 memory result, bit3 load data |

## Verification
Directed patterns set each priority level apart from the one below it. These include an immediate form whose destination field happens to equal a producer destination, a hazard through a register-ALU producer and through an immediate-ALU producer, a load-data hit with no memory-stage hit, and double hits on both sources. Non-writing producers are given field values that would match if they were wrongly qualified, which separates correct qualification from bare field comparison. A full sweep then crosses every execute-stage class with every memory-stage and write-back class and with every target choice: first source, second source, or neither. The scoreboard model computes the expected selects and operands for each vector, which catches any priority inversion, any missed qualification and any wrong field position.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int INSN_W = 32;
  localparam int OPC_W  = 6;
  localparam int REG_W  = 5;
  localparam int SEL_W  = 4;
  localparam int NUM_STAGES = 3;
  localparam int NUM_LANES  = 2;

  // Fields are numbered from the MSB; convert to LSB-based word indices.
  localparam int OPC_LSB = INSN_W - OPC_W;
  localparam int RS1_LSB = OPC_LSB - REG_W;
  localparam int RS2_LSB = RS1_LSB - REG_W;
  localparam int RD_LSB  = RS2_LSB - REG_W;

  // One-hot select bit positions (shared by both lanes).
  localparam int SEL_REG = 0;
  localparam int SEL_ALT = 1;
  localparam int SEL_EXM = 2;
  localparam int SEL_LMD = 3;

  typedef struct packed {
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [REG_W-1:0] dst;
    logic             reads_rs1;
    logic             reads_rs2;
    logic             use_imm;
    logic             is_branch;
    logic             alu_wr;
    logic             ld_wr;
  } insn_info_t;
endpackage

// File: rtl/fwd_decode.sv
module fwd_decode
  import fwd_pkg::*;
#(
  parameter logic [OPC_W-1:0] OP_RALU   = 6'd1,
  parameter logic [OPC_W-1:0] OP_IALU   = 6'd8,
  parameter logic [OPC_W-1:0] OP_LOAD   = 6'd35,
  parameter logic [OPC_W-1:0] OP_STORE  = 6'd43,
  parameter logic [OPC_W-1:0] OP_BRANCH = 6'd4
) (
  input  logic [INSN_W-1:0] insn,
  output insn_info_t        info
);
  logic [OPC_W-1:0] opc;
  logic is_r, is_ia, is_ld, is_st, is_br;
  logic unused_funct;

  assign opc   = insn[OPC_LSB +: OPC_W];
  assign is_r  = (opc == OP_RALU);
  assign is_ia = (opc == OP_IALU);
  assign is_ld = (opc == OP_LOAD);
  assign is_st = (opc == OP_STORE);
  assign is_br = (opc == OP_BRANCH);
  assign unused_funct = ^insn[RD_LSB-1:0];

  always_comb begin
    info.rs1       = insn[RS1_LSB +: REG_W];
    info.rs2       = insn[RS2_LSB +: REG_W];
    info.dst       = is_r ? insn[RD_LSB +: REG_W] : insn[RS2_LSB +: REG_W];
    info.reads_rs1 = is_r | is_ia | is_ld | is_st;
    info.reads_rs2 = is_r;
    info.use_imm   = is_ia | is_ld | is_st | is_br;
    info.is_branch = is_br;
    info.alu_wr    = is_r | is_ia;
    info.ld_wr     = is_ld;
  end
endmodule

// File: rtl/fwd_lane_sel.sv
module fwd_lane_sel
  import fwd_pkg::*;
(
  input  logic             use_alt,
  input  logic             reads,
  input  logic [REG_W-1:0] src,
  input  logic             exm_wr,
  input  logic [REG_W-1:0] exm_dst,
  input  logic             mwb_wr,
  input  logic [REG_W-1:0] mwb_dst,
  output logic [SEL_W-1:0] sel
);
  logic exm_hit, mwb_hit;

  assign exm_hit = reads && exm_wr && (exm_dst == src);
  assign mwb_hit = reads && mwb_wr && (mwb_dst == src);

  always_comb begin
    sel = '0;
    if (use_alt)      sel[SEL_ALT] = 1'b1;
    else if (exm_hit) sel[SEL_EXM] = 1'b1;
    else if (mwb_hit) sel[SEL_LMD] = 1'b1;
    else              sel[SEL_REG] = 1'b1;
  end
endmodule

// File: rtl/fwd_onehot_mux.sv
module fwd_onehot_mux #(
  parameter int DW = 32,
  parameter int N  = 4
) (
  input  logic [N-1:0]         sel,
  input  logic [N-1:0][DW-1:0] din,
  output logic [DW-1:0]        dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) dout = dout | din[i];
    end
  end
endmodule

// File: rtl/alu_fwd_sel.sv
module alu_fwd_sel
  import fwd_pkg::*;
#(
  parameter int DW = 32,
  parameter logic [OPC_W-1:0] OP_RALU   = 6'd1,
  parameter logic [OPC_W-1:0] OP_IALU   = 6'd8,
  parameter logic [OPC_W-1:0] OP_LOAD   = 6'd35,
  parameter logic [OPC_W-1:0] OP_STORE  = 6'd43,
  parameter logic [OPC_W-1:0] OP_BRANCH = 6'd4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] ex_insn,
  input  logic [INSN_W-1:0] mem_insn,
  input  logic [INSN_W-1:0] wb_insn,
  input  logic [DW-1:0]     next_pc,
  input  logic [DW-1:0]     rf_a,
  input  logic [DW-1:0]     rf_b,
  input  logic [DW-1:0]     imm_ext,
  input  logic [DW-1:0]     mem_alu_res,
  input  logic [DW-1:0]     wb_load_data,
  output logic [DW-1:0]     opnd_hi,
  output logic [DW-1:0]     opnd_lo,
  output logic [SEL_W-1:0]  sel_hi,
  output logic [SEL_W-1:0]  sel_lo
);
  localparam int ST_EX  = 0;
  localparam int ST_MEM = 1;
  localparam int ST_WB  = 2;
  localparam int LN_HI  = 0;
  localparam int LN_LO  = 1;

  logic [NUM_STAGES-1:0][INSN_W-1:0] stage_insn;
  insn_info_t info [NUM_STAGES];
  logic unused_info;

  assign stage_insn = {wb_insn, mem_insn, ex_insn};

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_dec
    fwd_decode #(
      .OP_RALU(OP_RALU), .OP_IALU(OP_IALU), .OP_LOAD(OP_LOAD),
      .OP_STORE(OP_STORE), .OP_BRANCH(OP_BRANCH)
    ) u_dec (
      .insn(stage_insn[s]),
      .info(info[s])
    );
  end

  assign unused_info = ^{info[ST_EX], info[ST_MEM], info[ST_WB]};

  logic [NUM_LANES-1:0]                      lane_alt;
  logic [NUM_LANES-1:0]                      lane_reads;
  logic [NUM_LANES-1:0][REG_W-1:0]           lane_src;
  logic [NUM_LANES-1:0][SEL_W-1:0]           lane_sel;
  logic [NUM_LANES-1:0][SEL_W-1:0][DW-1:0]   lane_cand;
  logic [NUM_LANES-1:0][DW-1:0]              lane_out;

  assign lane_alt[LN_HI]   = info[ST_EX].is_branch;
  assign lane_reads[LN_HI] = info[ST_EX].reads_rs1;
  assign lane_src[LN_HI]   = info[ST_EX].rs1;
  assign lane_cand[LN_HI]  = {wb_load_data, mem_alu_res, next_pc, rf_a};

  assign lane_alt[LN_LO]   = info[ST_EX].use_imm;
  assign lane_reads[LN_LO] = info[ST_EX].reads_rs2;
  assign lane_src[LN_LO]   = info[ST_EX].rs2;
  assign lane_cand[LN_LO]  = {wb_load_data, mem_alu_res, imm_ext, rf_b};

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    fwd_lane_sel u_sel (
      .use_alt(lane_alt[l]),
      .reads  (lane_reads[l]),
      .src    (lane_src[l]),
      .exm_wr (info[ST_MEM].alu_wr),
      .exm_dst(info[ST_MEM].dst),
      .mwb_wr (info[ST_WB].ld_wr),
      .mwb_dst(info[ST_WB].dst),
      .sel    (lane_sel[l])
    );
    fwd_onehot_mux #(.DW(DW), .N(SEL_W)) u_mux (
      .sel (lane_sel[l]),
      .din (lane_cand[l]),
      .dout(lane_out[l])
    );
  end

  logic [NUM_LANES-1:0][SEL_W-1:0] sel_q;
  logic [NUM_LANES-1:0][DW-1:0]    opnd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < NUM_LANES; l++) begin
        sel_q[l]  <= SEL_W'(1) << SEL_REG;
        opnd_q[l] <= '0;
      end
    end else begin
      sel_q  <= lane_sel;
      opnd_q <= lane_out;
    end
  end

  assign sel_hi  = sel_q[LN_HI];
  assign sel_lo  = sel_q[LN_LO];
  assign opnd_hi = opnd_q[LN_HI];
  assign opnd_lo = opnd_q[LN_LO];
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker
  import fwd_pkg::*;
#(
  parameter int DW = 32,
  parameter logic [OPC_W-1:0] OP_IALU   = 6'd8,
  parameter logic [OPC_W-1:0] OP_LOAD   = 6'd35,
  parameter logic [OPC_W-1:0] OP_STORE  = 6'd43,
  parameter logic [OPC_W-1:0] OP_BRANCH = 6'd4
) (
  input logic              clk,
  input logic              rst,
  input logic [INSN_W-1:0] ex_insn,
  input logic [INSN_W-1:0] mem_insn,
  input logic [INSN_W-1:0] wb_insn,
  input logic [DW-1:0]     rf_b,
  input logic [DW-1:0]     mem_alu_res,
  input logic [DW-1:0]     opnd_lo,
  input logic [SEL_W-1:0]  sel_hi,
  input logic [SEL_W-1:0]  sel_lo
);
  logic armed;
  logic [OPC_W-1:0] ex_opc;

  assign ex_opc = ex_insn[OPC_LSB +: OPC_W];

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R1: first edge after reset shows the reset selects
  p_reset_sel_r1: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (sel_hi == 4'b0001 && sel_lo == 4'b0001));

  // R11: one-hot selects
  p_sel_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    ($countones(sel_hi) == 1) && ($countones(sel_lo) == 1));

  // R3: immediate-form execute instruction takes the immediate
  p_imm_lower_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(ex_opc == OP_IALU || ex_opc == OP_LOAD ||
                    ex_opc == OP_STORE || ex_opc == OP_BRANCH)) |-> sel_lo[SEL_ALT]);

  // R6: branch takes the next address on the upper input
  p_branch_upper_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(ex_opc == OP_BRANCH)) |-> sel_hi[SEL_ALT]);

  // R9: no-op producers never forward
  p_nop_no_fwd_r9: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(mem_insn == '0 && wb_insn == '0)) |->
      !(sel_hi[SEL_EXM] || sel_hi[SEL_LMD] || sel_lo[SEL_EXM] || sel_lo[SEL_LMD]));

  // R11: register path carries the sampled register B value
  p_reg_value_r11: assert property (@(posedge clk) disable iff (rst)
    (armed && sel_lo[SEL_REG]) |-> (opnd_lo == $past(rf_b)));

  // R4: forwarded path carries the sampled memory-stage result
  p_exm_value_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && sel_lo[SEL_EXM]) |-> (opnd_lo == $past(mem_alu_res)));
endmodule

bind alu_fwd_sel fwd_checker #(
  .DW(DW), .OP_IALU(OP_IALU), .OP_LOAD(OP_LOAD),
  .OP_STORE(OP_STORE), .OP_BRANCH(OP_BRANCH)
) u_fwd_chk (
  .clk(clk), .rst(rst), .ex_insn(ex_insn), .mem_insn(mem_insn),
  .wb_insn(wb_insn), .rf_b(rf_b), .mem_alu_res(mem_alu_res),
  .opnd_lo(opnd_lo), .sel_hi(sel_hi), .sel_lo(sel_lo)
);

// File: tb/test_alu_fwd_sel.sv
module test_alu_fwd_sel;
  localparam int DW = 32;
  localparam logic [5:0] O_NOP = 6'd0, O_R = 6'd1, O_I = 6'd8, O_LD = 6'd35,
                         O_ST = 6'd43, O_BR = 6'd4, O_J = 6'd2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [31:0]   ex_insn = '0, mem_insn = '0, wb_insn = '0;
  logic [DW-1:0] next_pc = '0, rf_a = '0, rf_b = '0, imm_ext = '0;
  logic [DW-1:0] mem_alu_res = '0, wb_load_data = '0;
  logic [DW-1:0] opnd_hi, opnd_lo;
  logic [3:0]    sel_hi, sel_lo;

  alu_fwd_sel i_alu_fwd_sel (
    .clk(clk), .rst(rst), .ex_insn(ex_insn), .mem_insn(mem_insn),
    .wb_insn(wb_insn), .next_pc(next_pc), .rf_a(rf_a), .rf_b(rf_b),
    .imm_ext(imm_ext), .mem_alu_res(mem_alu_res), .wb_load_data(wb_load_data),
    .opnd_hi(opnd_hi), .opnd_lo(opnd_lo), .sel_hi(sel_hi), .sel_lo(sel_lo)
  );

  typedef struct {
    logic [3:0]    sh, sl;
    logic [DW-1:0] oh, ol;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;

  function automatic logic [31:0] mkw(logic [5:0] op, logic [4:0] s1, logic [4:0] s2, logic [4:0] d);
    if (op == O_NOP) return 32'h0;
    if (op == O_J)   return {op, 26'h2A5A5A5};
    if (op == O_R)   return {op, s1, s2, d, 11'h2A};
    return {op, s1, s2, 16'h8F3C};
  endfunction

  function automatic logic alu_hit(logic [31:0] w, logic [4:0] r);
    if (w[31:26] == O_R) return w[15:11] == r;
    if (w[31:26] == O_I) return w[20:16] == r;
    return 1'b0;
  endfunction

  function automatic logic ld_hit(logic [31:0] w, logic [4:0] r);
    return (w[31:26] == O_LD) && (w[20:16] == r);
  endfunction

  task automatic drive(logic [31:0] ie, logic [31:0] ee, logic [31:0] me, string tag);
    exp_t e;
    logic [5:0] op;
    logic [4:0] r1, r2;
    @(negedge clk);
    ex_insn = ie; mem_insn = ee; wb_insn = me;
    next_pc = $urandom; rf_a = $urandom; rf_b = $urandom; imm_ext = $urandom;
    mem_alu_res = $urandom; wb_load_data = $urandom;
    op = ie[31:26]; r1 = ie[25:21]; r2 = ie[20:16];
    e.tag = tag;
    if (op == O_BR) begin e.sh = 4'b0010; e.oh = next_pc; end
    else if (op == O_R || op == O_I || op == O_LD || op == O_ST) begin
      if (alu_hit(ee, r1))     begin e.sh = 4'b0100; e.oh = mem_alu_res; end
      else if (ld_hit(me, r1)) begin e.sh = 4'b1000; e.oh = wb_load_data; end
      else                     begin e.sh = 4'b0001; e.oh = rf_a; end
    end else begin e.sh = 4'b0001; e.oh = rf_a; end
    if (op == O_I || op == O_LD || op == O_ST || op == O_BR) begin
      e.sl = 4'b0010; e.ol = imm_ext;
    end else if (op == O_R) begin
      if (alu_hit(ee, r2))     begin e.sl = 4'b0100; e.ol = mem_alu_res; end
      else if (ld_hit(me, r2)) begin e.sl = 4'b1000; e.ol = wb_load_data; end
      else                     begin e.sl = 4'b0001; e.ol = rf_b; end
    end else begin e.sl = 4'b0001; e.ol = rf_b; end
    q.push_back(e);
  endtask

  // Monitor: compares each result one clock after its inputs were driven (R2)
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (sel_hi !== e.sh || sel_lo !== e.sl || opnd_hi !== e.oh || opnd_lo !== e.ol) begin
          fails++;
          $display("FAIL %s: sel_hi=%b sel_lo=%b hi=%h lo=%h expected sel_hi=%b sel_lo=%b hi=%h lo=%h",
                   e.tag, sel_hi, sel_lo, opnd_hi, opnd_lo, e.sh, e.sl, e.oh, e.ol);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam logic [5:0] OPS [7] = '{O_NOP, O_R, O_I, O_LD, O_ST, O_BR, O_J};

  initial begin
    // R1: inputs that would forward are present during reset
    ex_insn  = mkw(O_BR, 5'd3, 5'd4, 5'd0);
    mem_insn = mkw(O_R, 5'd1, 5'd1, 5'd3);
    rf_a = 32'hDEAD_BEEF; rf_b = 32'h1234_5678; mem_alu_res = 32'h5555_AAAA;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (sel_hi !== 4'b0001 || sel_lo !== 4'b0001 || opnd_hi !== '0 || opnd_lo !== '0) begin
      fails++;
      $display("FAIL R1: sel_hi=%b sel_lo=%b hi=%h lo=%h expected 0001 0001 0 0",
               sel_hi, sel_lo, opnd_hi, opnd_lo);
    end

    // R10 / R2: no hazards, back to back
    drive(mkw(O_R, 5'd3, 5'd5, 5'd9), mkw(O_R, 5'd1, 5'd2, 5'd7), mkw(O_LD, 5'd0, 5'd8, 5'd8), "R10");
    drive(mkw(O_R, 5'd4, 5'd6, 5'd9), mkw(O_I, 5'd1, 5'd2, 5'd2), mkw(O_LD, 5'd0, 5'd3, 5'd3), "R2");
    // R3: immediate forms, destination field equal to producer destination
    drive(mkw(O_I, 5'd3, 5'd7, 5'd7), mkw(O_R, 5'd1, 5'd2, 5'd7), 32'h0, "R3");
    drive(mkw(O_ST, 5'd9, 5'd7, 5'd7), mkw(O_R, 5'd1, 5'd2, 5'd7), mkw(O_LD, 5'd0, 5'd7, 5'd7), "R3");
    // R4: register-form hazard through each producer type
    drive(mkw(O_R, 5'd2, 5'd7, 5'd3), mkw(O_R, 5'd1, 5'd2, 5'd7), 32'h0, "R4");
    drive(mkw(O_R, 5'd2, 5'd11, 5'd3), mkw(O_I, 5'd1, 5'd11, 5'd11), 32'h0, "R4");
    // R5: load data from write-back
    drive(mkw(O_R, 5'd2, 5'd5, 5'd3), mkw(O_R, 5'd1, 5'd2, 5'd9), mkw(O_LD, 5'd0, 5'd5, 5'd5), "R5");
    // R6: branch
    drive(mkw(O_BR, 5'd4, 5'd6, 5'd0), mkw(O_R, 5'd1, 5'd2, 5'd4), mkw(O_LD, 5'd0, 5'd4, 5'd4), "R6");
    // R7: upper input hazards
    drive(mkw(O_R, 5'd12, 5'd6, 5'd3), mkw(O_R, 5'd1, 5'd2, 5'd12), 32'h0, "R7");
    drive(mkw(O_LD, 5'd13, 5'd6, 5'd6), 32'h0, mkw(O_LD, 5'd0, 5'd13, 5'd13), "R7");
    // R8: both stages match
    drive(mkw(O_R, 5'd14, 5'd15, 5'd3), mkw(O_R, 5'd1, 5'd2, 5'd15), mkw(O_LD, 5'd0, 5'd15, 5'd15), "R8");
    drive(mkw(O_I, 5'd14, 5'd15, 5'd15), mkw(O_I, 5'd1, 5'd14, 5'd14), mkw(O_LD, 5'd0, 5'd14, 5'd14), "R8");
    // R9: non-writing or non-forwardable producers
    drive(mkw(O_R, 5'd16, 5'd17, 5'd3), mkw(O_ST, 5'd16, 5'd17, 5'd17), mkw(O_BR, 5'd16, 5'd17, 5'd17), "R9");
    drive(mkw(O_R, 5'd16, 5'd17, 5'd3), mkw(O_LD, 5'd0, 5'd17, 5'd17), mkw(O_R, 5'd1, 5'd2, 5'd16), "R9");
    drive(mkw(O_R, 5'd0, 5'd0, 5'd3), mkw(O_J, 5'd0, 5'd0, 5'd0), 32'h0, "R9");
    // R10: jump and no-op in execute
    drive(mkw(O_J, 5'd0, 5'd0, 5'd0), mkw(O_R, 5'd1, 5'd2, 5'd10), mkw(O_LD, 5'd0, 5'd10, 5'd10), "R10");
    drive(32'h0, mkw(O_R, 5'd1, 5'd2, 5'd0), mkw(O_LD, 5'd0, 5'd0, 5'd0), "R10");

    // R11: every class combination and target choice
    for (int ia = 0; ia < 7; ia++) begin
      for (int ea = 0; ea < 7; ea++) begin
        for (int ma = 0; ma < 7; ma++) begin
          for (int t = 0; t < 9; t++) begin
            logic [4:0] r1, r2, de, dm;
            r1 = 5'($urandom_range(0, 30));
            r2 = 5'($urandom_range(0, 30));
            de = (t % 3 == 0) ? r1 : (t % 3 == 1) ? r2 : 5'd31;
            dm = (t / 3 == 0) ? r1 : (t / 3 == 1) ? r2 : 5'd31;
            drive(mkw(OPS[ia], r1, r2, 5'd30), mkw(OPS[ea], 5'd31, de, de),
                  mkw(OPS[ma], 5'd31, dm, dm), "R11");
          end
        end
      end
    end

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule